// File: doc/BRIEF.md
# I2C Status Flag Register

This block holds the status byte of a two-wire serial controller. The controller core reports single-cycle events to it: a byte finished, the own address was matched, arbitration was lost, the acknowledge level sampled after a byte, and the read/write bit of the calling address. The block turns these events into sticky flags. Each flag has its own way of being cleared. Some clear when the data register is accessed, and the kind of access that counts depends on the transfer direction. One clears on any control-register write. The rest are cleared by software writing a one to them.

The block also watches the raw SCL and SDA lines, so it reports whether the bus is busy whether the controller is acting as master or as slave. Both lines pass through a synchronizer of parameterized depth. START and STOP conditions are then decoded from the synchronized lines. The interrupt flag is gated with an enable input to form the interrupt request.

Top module: `i2c_status_unit`

## Requirements
- R1: `stat_rdata` bit positions are: [7] byte-done, [6] addressed, [5] bus-busy, [4] arbitration-lost, [3] reserved and always 0, [2] slave direction, [1] interrupt flag, [0] acknowledge level.
- R2: After reset `stat_rdata` is 8'h80 and `irq` is 0.
- R3: Bit 7 sets one cycle after `ev_byte_done`. It clears after `dat_rd` when `xmit_mode`=0, or after `dat_wr` when `xmit_mode`=1. Any other data access leaves it unchanged.
- R4: Bit 6 sets one cycle after `ev_addr_match` and clears after any `ctl_wr`.
- R5: Bit 5 goes to 1 after SDA falls while SCL is high (START). It goes to 0 after SDA rises while SCL is high (STOP). SDA changes while SCL is low leave it unchanged.
- R6: Bit 4 sets on `ev_arb_lost`. It clears only on `stat_wr` with `stat_wdata[4]`=1.
- R7: Bit 1 sets on any of `ev_byte_done`, `ev_addr_match` or `ev_arb_lost`. It clears only on `stat_wr` with `stat_wdata[1]`=1.
- R8: `irq` equals bit 1 ANDed with `irq_en`.
- R9: Bit 0 loads `ev_rx_nack` on `ev_byte_done` (0 = ACK seen, 1 = no ACK). Bit 2 loads `ev_rw_bit` on `ev_addr_match` (1 = master reads). Both hold otherwise.
- R10: When a set event and a clear request reach the same flag in the same cycle, the flag ends up set.
- R11: On a `stat_wr`, zero bits in `stat_wdata` have no effect. Bits of `stat_wdata` at positions 7, 6, 5, 3, 2 and 0 also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| ev_byte_done | input | 1 | Byte transfer finished strobe |
| ev_addr_match | input | 1 | Own-address match strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_rx_nack | input | 1 | Sampled acknowledge level, valid with ev_byte_done |
| ev_rw_bit | input | 1 | Calling-address R/W bit, valid with ev_addr_match |
| xmit_mode | input | 1 | 1 = transmit direction, 0 = receive |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data |
| irq_en | input | 1 | Interrupt enable |
| stat_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 status write values against set flags. A design that decodes the wrong bit, or clears on writing zero, would drop or keep the wrong flag. It also sweeps every combination of direction and data access. A design that ignores direction would clear byte-done on the wrong access. Simultaneous set and clear requests are driven on each flag; a design where clear wins would show a zero where a one belongs. SDA is toggled while SCL is low, so a detector that does not qualify on SCL would flip the busy bit.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  localparam int STAT_W    = 8;
  localparam int B_XFER    = 7;
  localparam int B_ADDR    = 6;
  localparam int B_BUSY    = 5;
  localparam int B_ARB     = 4;
  localparam int B_RSVD    = 3;
  localparam int B_DIR     = 2;
  localparam int B_INT     = 1;
  localparam int B_ACK     = 0;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

  // sticky flag: set dominates clear
  function automatic logic f_sticky(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // byte-done clears on the data access that matches the direction
  function automatic logic f_xfer_clr(input logic xmit, input logic rd, input logic wr);
    return xmit ? wr : rd;
  endfunction

  function automatic logic [STAT_W-1:0] f_pack(
    input logic xfer, input logic addr, input logic busy, input logic arb,
    input logic dir, input logic intf, input logic ack);
    logic [STAT_W-1:0] s;
    s = '0;
    s[B_XFER] = xfer;
    s[B_ADDR] = addr;
    s[B_BUSY] = busy;
    s[B_ARB]  = arb;
    s[B_DIR]  = dir;
    s[B_INT]  = intf;
    s[B_ACK]  = ack;
    return s;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= 1'b1;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[g] <= 1'b1;
        else        sr[g] <= sr[g-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_q, sda_q, scl_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_high  = scl_s & scl_q;
  assign start_det = scl_high & sda_q & ~sda_s;
  assign stop_det  = scl_high & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
  import i2c_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_byte_done,
  input  logic              ev_addr_match,
  input  logic              ev_arb_lost,
  input  logic              ev_rx_nack,
  input  logic              ev_rw_bit,
  input  logic              xmit_mode,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic              ctl_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              busy,
  output logic [STAT_W-1:0] stat
);
  logic xfer_q, addr_q, arb_q, dir_q, int_q, ack_q;
  logic xfer_clr, arb_clr, int_clr, int_set;

  assign xfer_clr = f_xfer_clr(xmit_mode, dat_rd, dat_wr);
  assign arb_clr  = stat_wr & stat_wdata[B_ARB];
  assign int_clr  = stat_wr & stat_wdata[B_INT];
  assign int_set  = ev_byte_done | ev_addr_match | ev_arb_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= STAT_RESET[B_XFER];
      addr_q <= STAT_RESET[B_ADDR];
      arb_q  <= STAT_RESET[B_ARB];
      dir_q  <= STAT_RESET[B_DIR];
      int_q  <= STAT_RESET[B_INT];
      ack_q  <= STAT_RESET[B_ACK];
    end else begin
      xfer_q <= f_sticky(xfer_q, ev_byte_done, xfer_clr);
      addr_q <= f_sticky(addr_q, ev_addr_match, ctl_wr);
      arb_q  <= f_sticky(arb_q, ev_arb_lost, arb_clr);
      int_q  <= f_sticky(int_q, int_set, int_clr);
      if (ev_addr_match) dir_q <= ev_rw_bit;
      if (ev_byte_done)  ack_q <= ev_rx_nack;
    end
  end

  assign stat = f_pack(xfer_q, addr_q, busy, arb_q, dir_q, int_q, ack_q);
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
  import i2c_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ev_byte_done,
  input  logic       ev_addr_match,
  input  logic       ev_arb_lost,
  input  logic       ev_rx_nack,
  input  logic       ev_rw_bit,
  input  logic       xmit_mode,
  input  logic       dat_rd,
  input  logic       dat_wr,
  input  logic       ctl_wr,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic       irq_en,
  output logic [7:0] stat_rdata,
  output logic       irq
);
  logic scl_s, sda_s;
  logic start_det, stop_det, bus_busy;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2c_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .busy(bus_busy));

  i2c_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_byte_done(ev_byte_done), .ev_addr_match(ev_addr_match),
    .ev_arb_lost(ev_arb_lost), .ev_rx_nack(ev_rx_nack), .ev_rw_bit(ev_rw_bit),
    .xmit_mode(xmit_mode), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .ctl_wr(ctl_wr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .busy(bus_busy), .stat(stat_rdata));

  assign irq = stat_rdata[B_INT] & irq_en;
endmodule

// File: rtl/i2c_status_chk.sv
module i2c_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_byte_done,
  input logic       ev_addr_match,
  input logic       ev_arb_lost,
  input logic       ev_rx_nack,
  input logic       ev_rw_bit,
  input logic       ctl_wr,
  input logic       stat_wr,
  input logic [7:0] stat_wdata,
  input logic       irq_en,
  input logic       start_det,
  input logic       stop_det,
  input logic [7:0] stat_rdata,
  input logic       irq
);
  p_xfer_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done |=> stat_rdata[7]);
  p_addr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ev_addr_match) |=> !stat_rdata[6]);
  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> stat_rdata[5]);
  p_busy_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stat_rdata[5]);
  p_arb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_arb_lost && !(stat_wr && stat_wdata[4])) |=> $stable(stat_rdata[4]));
  p_int_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_done || ev_addr_match || ev_arb_lost) |=> stat_rdata[1]);
  p_int_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[1] && !ev_byte_done && !ev_addr_match && !ev_arb_lost)
      |=> !stat_rdata[1]);
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_ack_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done |=> (stat_rdata[0] == $past(ev_rx_nack)));
  p_dir_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> (stat_rdata[2] == $past(ev_rw_bit)));
endmodule

bind i2c_status_unit i2c_status_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_byte_done(ev_byte_done), .ev_addr_match(ev_addr_match),
  .ev_arb_lost(ev_arb_lost), .ev_rx_nack(ev_rx_nack), .ev_rw_bit(ev_rw_bit),
  .ctl_wr(ctl_wr), .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
  .start_det(start_det), .stop_det(stop_det),
  .stat_rdata(stat_rdata), .irq(irq));

// File: tb/test_i2c_status_unit.sv
`timescale 1ns/1ps
module test_i2c_status_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic bd = 0, am = 0, al = 0, nack = 0, rw = 0, xm = 0;
  logic drd = 0, dwr = 0, cwr = 0, swr = 0, irq_en = 0;
  logic [7:0] wd = '0;
  logic [7:0] stat_rdata;
  logic irq;
  logic [7:0] exp_s;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_status_unit i_i2c_status_unit (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .ev_byte_done(bd), .ev_addr_match(am), .ev_arb_lost(al),
    .ev_rx_nack(nack), .ev_rw_bit(rw), .xmit_mode(xm),
    .dat_rd(drd), .dat_wr(dwr), .ctl_wr(cwr), .stat_wr(swr),
    .stat_wdata(wd), .irq_en(irq_en), .stat_rdata(stat_rdata), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle of strobes; model the flags from the requirements, then compare
  task automatic cyc(input string req,
                     input logic b, a, l, nk, r, x, rd, wr, cw, sw,
                     input logic [7:0] w);
    logic [7:0] e;
    bd = b; am = a; al = l; nack = nk; rw = r; xm = x;
    drd = rd; dwr = wr; cwr = cw; swr = sw; wd = w;
    e = exp_s;
    e[7] = b | (exp_s[7] & ~(x ? wr : rd));
    e[6] = a | (exp_s[6] & ~cw);
    e[4] = l | (exp_s[4] & ~(sw & w[4]));
    e[1] = (b | a | l) | (exp_s[1] & ~(sw & w[1]));
    if (a) e[2] = r;
    if (b) e[0] = nk;
    e[3] = 1'b0;
    exp_s = e;
    @(negedge clk);
    bd = 0; am = 0; al = 0; drd = 0; dwr = 0; cwr = 0; swr = 0; wd = '0;
    check(req, stat_rdata, exp_s);
    check({req, "/R8 irq"}, {7'd0, irq}, {7'd0, exp_s[1] & irq_en});
  endtask

  task automatic lines(input logic c, input logic d);
    scl_i = c; sda_i = d;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_s = 8'h80;
    check("R2 reset", stat_rdata, 8'h80);
    check("R2 irq reset", {7'd0, irq}, 8'h00);

    // R3: direction-dependent clear, all access combinations
    for (int k = 0; k < 8; k++) begin
      cyc("R3 set", 1, 0, 0, k[0], 0, 0, 0, 0, 0, 0, 8'h00);
      cyc("R3 access", 0, 0, 0, 0, 0, k[2], k[1], k[0], 0, 0, 8'h00);
    end
    // R9: ack level and direction capture, hold otherwise
    cyc("R9 nack", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
    cyc("R9 hold", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    cyc("R9 ack", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    cyc("R9 dir rd", 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    cyc("R9 dir hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    cyc("R9 dir wr", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    // R4: control write clears addressed
    cyc("R4 set", 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    cyc("R4 clr", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
    // R6 R7 R11 R1: sweep every write value with flags set
    irq_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      cyc("R6 set", 1, 1, 1, v[0], v[1], 0, 0, 0, 0, 0, 8'h00);
      cyc("R11 R1 w1c sweep", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v[7:0]);
    end
    // R10: set beats clear on each flag
    cyc("R10 xfer", 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 8'h00);
    cyc("R10 addr", 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
    cyc("R10 arb/int", 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 8'h12);
    cyc("R7 clr", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h02);
    cyc("R7 byte only", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    irq_en = 1'b0;
    @(negedge clk);
    check("R8 masked", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    @(negedge clk);
    check("R8 enabled", {7'd0, irq}, {7'd0, exp_s[1]});

    // R5: bus-busy via START/STOP
    lines(1, 1);
    check("R5 idle", {7'd0, stat_rdata[5]}, 8'h00);
    lines(1, 0);
    check("R5 start", {7'd0, stat_rdata[5]}, 8'h01);
    lines(0, 0);
    lines(0, 1);
    lines(0, 0);
    check("R5 sda toggles scl low", {7'd0, stat_rdata[5]}, 8'h01);
    lines(1, 0);
    lines(1, 1);
    check("R5 stop", {7'd0, stat_rdata[5]}, 8'h00);
    lines(0, 1);
    lines(0, 0);
    lines(0, 1);
    check("R5 no start scl low", {7'd0, stat_rdata[5]}, 8'h00);
    lines(1, 1);
    lines(1, 0);
    exp_s[5] = 1'b1;
    check("R5 restart busy", stat_rdata, exp_s);
    cyc("R5 R1 flags with busy", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
    lines(1, 1);
    exp_s[5] = 1'b0;
    check("R5 stop again", stat_rdata, exp_s);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule